// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block models the control and status side of a serial NOR flash program/erase engine. It takes commands that have already been decoded, one per clock, and a per-sector lock vector. It keeps a write-enable latch and an 8-bit flag status register. A program or a whole-die erase runs as a countdown whose length is set by a parameter. No memory array contents are modelled. The serial shifting of commands and data is handled elsewhere. The surrounding logic sends a read-flags command each time one complete status byte has been shifted out to the host. The value in that byte is the `flag_status` seen at that clock.

A running operation can be paused. A suspend command does not take effect at once. First the controller marks which kind of operation was interrupted. It then waits a fixed latency before raising the ready bit. It counts as suspended only after the host has actually received a status byte with the ready bit at 1. From then on only a resume releases it, and the countdown continues from where it stopped. An erase request is refused if any sector is locked. A refused erase leaves the write-enable latch set and raises two error flags.

Top module: `nor_pe_status_ctrl`

## Requirements
- R1: After reset, `flag_status` is 0x80 (bit 7 = ready, 1 means idle or ready), `wel` is 0, and `busy` and `suspended` are 0.
- R2: The command codes are: 0 none, 1 write-enable, 2 die erase, 3 program, 4 suspend, 5 resume, 6 read-flags (one status byte completed). Write-enable sets `wel` when the controller is idle. A die erase or program issued while `wel` is 0 is ignored: `busy` stays 0 and the flags are unchanged.
- R3: A die erase issued while `wel` is 1 and any bit of `sector_lock` is set is rejected. On the next clock, `wel` is still 1, `busy` is 0, and flag bits 1 (protection error) and 5 (erase error) are set.
- R4: An accepted die erase clears bit 7 on the next clock and sets `busy`. Bit 7 returns to 1 and `wel` clears exactly ERASE_CYCLES clocks after the command.
- R5: An accepted program behaves like R4, using PROG_CYCLES, and also clears `wel` when it completes.
- R6: A suspend during a program sets bit 2 on the next clock. A suspend during an erase sets bit 6 on the next clock. `busy` drops at that clock, and bit 7 rises SUSP_LATENCY clocks after the suspend.
- R7: `suspended` rises only on a read-flags command issued while bit 7 is already 1 after a suspend. A read-flags command issued while bit 7 is still 0 has no effect. A resume issued before `suspended` is high is ignored.
- R8: A resume while `suspended` is 1 clears bit 7 and the suspend bit (2 or 6) on the next clock. The countdown then resumes, and the operation completes after the clocks it still had left when it was suspended.
- R9: A suspend issued while the controller is idle, waiting out the suspend latency, or already suspended is ignored: the flags and `suspended` stay unchanged.
- R10: Error flag bits 1 and 5 stay set until reset, including through a later operation that succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this clock |
| cmd_code | input | 3 | Decoded command code (see R2) |
| sector_lock | input | NUM_SECTORS | One lock bit per sector, sampled when a die erase is issued |
| wel | output | 1 | Write-enable latch |
| flag_status | output | 8 | Flag status register |
| busy | output | 1 | A program or erase countdown is running |
| suspended | output | 1 | The interrupted operation is fully suspended |

## Verification
Five properties are checked on every clock:
- a refused erase keeps the latch set and raises both error bits;
- the ready bit stays low while a countdown runs;
- `suspended` rises only after a read-flags command that saw the ready bit at 1;
- `suspended` falls only after a resume;
- a suspend issued while idle leaves the flags untouched.

Some behaviour only the bench scenarios can show. These are the exact completion clocks, and the fact that the remaining countdown survives a suspension at every possible offset. They also include the full sweep of lock patterns, and the sticky error bits persisting through a later successful erase.

// File: rtl/nor_pe_pkg.sv
package nor_pe_pkg;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_WREN       = 3'd1,
        CMD_DIE_ERASE  = 3'd2,
        CMD_PROGRAM    = 3'd3,
        CMD_SUSPEND    = 3'd4,
        CMD_RESUME     = 3'd5,
        CMD_READ_FLAGS = 3'd6
    } pe_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_SUSP_PEND,
        ST_SUSP_SHOWN,
        ST_SUSPENDED
    } pe_state_e;

    typedef enum logic {
        OP_PROGRAM,
        OP_ERASE
    } pe_op_e;

    localparam int FB_READY      = 7;
    localparam int FB_ERASE_SUSP = 6;
    localparam int FB_ERASE_ERR  = 5;
    localparam int FB_PROG_SUSP  = 2;
    localparam int FB_PROT_ERR   = 1;

    localparam logic [7:0] FLAGS_RESET = 8'h80;

    typedef struct packed {
        logic [7:0] set;
        logic [7:0] clr;
    } flag_upd_t;

    function automatic logic [7:0] bit_mask(input int pos);
        return 8'(1) << pos;
    endfunction

    function automatic logic [7:0] suspend_mask(input pe_op_e op);
        return (op == OP_ERASE) ? bit_mask(FB_ERASE_SUSP) : bit_mask(FB_PROG_SUSP);
    endfunction

endpackage

// File: rtl/pe_countdown.sv
module pe_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

    // R8: a counter that reached zero never wraps while running
    p_hold_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && run && zero) |=> zero);

endmodule

// File: rtl/pe_lock_check.sv
module pe_lock_check #(
    parameter int NUM_SECTORS = 16,
    parameter int GROUP       = 4
) (
    input  logic [NUM_SECTORS-1:0] sector_lock,
    output logic                   any_locked
);
    localparam int NG  = (NUM_SECTORS + GROUP - 1) / GROUP;
    localparam int PAD = NG * GROUP;

    logic [PAD-1:0] padded;
    logic [NG-1:0]  grp_hit;

    assign padded = PAD'(sector_lock);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_hit[g] = |padded[g*GROUP +: GROUP];
    end

    assign any_locked = |grp_hit;

endmodule

// File: rtl/pe_flag_reg.sv
module pe_flag_reg
    import nor_pe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_upd_t upd,
    output logic [7:0] flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= FLAGS_RESET;
        else
            flags <= (flags & ~upd.clr) | upd.set;
    end

    // R10: a single update never both sets and clears the same bit
    p_masks_disjoint_r10: assert property (@(posedge clk) disable iff (rst)
        (upd.set & upd.clr) == 8'h00);

    // R10: error bits are sticky once set
    p_sticky_err_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flags[FB_ERASE_ERR]) && $past(flags[FB_PROT_ERR]))
        |-> (flags[FB_ERASE_ERR] && flags[FB_PROT_ERR]));

endmodule

// File: rtl/nor_pe_status_ctrl.sv
module nor_pe_status_ctrl
    import nor_pe_pkg::*;
#(
    parameter int NUM_SECTORS  = 512,
    parameter int ERASE_CYCLES = 4096,
    parameter int PROG_CYCLES  = 256,
    parameter int SUSP_LATENCY = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_code,
    input  logic [NUM_SECTORS-1:0] sector_lock,
    output logic                   wel,
    output logic [7:0]             flag_status,
    output logic                   busy,
    output logic                   suspended
);
    localparam int MAX_DUR = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int OP_W    = (MAX_DUR > 1) ? $clog2(MAX_DUR) : 1;
    localparam int LAT_W   = (SUSP_LATENCY > 1) ? $clog2(SUSP_LATENCY) : 1;
    localparam logic [OP_W-1:0]  ERASE_LD = OP_W'(ERASE_CYCLES - 1);
    localparam logic [OP_W-1:0]  PROG_LD  = OP_W'(PROG_CYCLES - 1);
    localparam logic [LAT_W-1:0] LAT_LD   = LAT_W'(SUSP_LATENCY - 1);

    pe_cmd_e   cmd;
    pe_state_e st, st_n;
    pe_op_e    op, op_n;
    logic      wel_n;
    flag_upd_t upd;
    logic      any_locked;
    logic      op_load, op_run, op_zero;
    logic [OP_W-1:0] op_val;
    logic      lat_load, lat_run, lat_zero;

    assign cmd = cmd_valid ? pe_cmd_e'(cmd_code) : CMD_NONE;

    pe_lock_check #(.NUM_SECTORS(NUM_SECTORS)) u_lock (
        .sector_lock (sector_lock),
        .any_locked  (any_locked)
    );

    pe_countdown #(.W(OP_W)) u_op_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (op_load),
        .load_val (op_val),
        .run      (op_run),
        .zero     (op_zero)
    );

    pe_countdown #(.W(LAT_W)) u_lat_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (lat_load),
        .load_val (LAT_LD),
        .run      (lat_run),
        .zero     (lat_zero)
    );

    pe_flag_reg u_flags (
        .clk   (clk),
        .rst   (rst),
        .upd   (upd),
        .flags (flag_status)
    );

    always_comb begin
        st_n     = st;
        op_n     = op;
        wel_n    = wel;
        upd      = '0;
        op_load  = 1'b0;
        op_val   = PROG_LD;
        op_run   = 1'b0;
        lat_load = 1'b0;
        lat_run  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                unique case (cmd)
                    CMD_WREN: wel_n = 1'b1;
                    CMD_DIE_ERASE: begin
                        if (wel) begin
                            if (any_locked) begin
                                upd.set = bit_mask(FB_PROT_ERR) | bit_mask(FB_ERASE_ERR);
                            end else begin
                                st_n    = ST_BUSY;
                                op_n    = OP_ERASE;
                                op_load = 1'b1;
                                op_val  = ERASE_LD;
                                upd.clr = bit_mask(FB_READY);
                            end
                        end
                    end
                    CMD_PROGRAM: begin
                        if (wel) begin
                            st_n    = ST_BUSY;
                            op_n    = OP_PROGRAM;
                            op_load = 1'b1;
                            op_val  = PROG_LD;
                            upd.clr = bit_mask(FB_READY);
                        end
                    end
                    default: ;
                endcase
            end
            ST_BUSY: begin
                if (op_zero) begin
                    st_n    = ST_IDLE;
                    wel_n   = 1'b0;
                    upd.set = bit_mask(FB_READY);
                end else if (cmd == CMD_SUSPEND) begin
                    st_n     = ST_SUSP_PEND;
                    lat_load = 1'b1;
                    upd.set  = suspend_mask(op);
                end else begin
                    op_run = 1'b1;
                end
            end
            ST_SUSP_PEND: begin
                if (lat_zero) begin
                    st_n    = ST_SUSP_SHOWN;
                    upd.set = bit_mask(FB_READY);
                end else begin
                    lat_run = 1'b1;
                end
            end
            ST_SUSP_SHOWN: begin
                if (cmd == CMD_READ_FLAGS && flag_status[FB_READY])
                    st_n = ST_SUSPENDED;
            end
            ST_SUSPENDED: begin
                if (cmd == CMD_RESUME) begin
                    st_n    = ST_BUSY;
                    upd.clr = suspend_mask(op) | bit_mask(FB_READY);
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            op  <= OP_PROGRAM;
            wel <= 1'b0;
        end else begin
            st  <= st_n;
            op  <= op_n;
            wel <= wel_n;
        end
    end

    assign busy      = (st == ST_BUSY);
    assign suspended = (st == ST_SUSPENDED);

    // R3: a refused erase keeps the latch set and raises both error bits
    p_reject_keeps_wel_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cmd == CMD_DIE_ERASE && wel && any_locked)
        |=> (wel && flag_status[FB_PROT_ERR] && flag_status[FB_ERASE_ERR] && !busy));

    // R4: ready bit is low whenever a countdown runs
    p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !flag_status[FB_READY]);

    // R7: suspension is entered only after a status read that saw ready = 1
    p_enter_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(suspended) |-> $past(cmd == CMD_READ_FLAGS && flag_status[FB_READY]));

    // R8: suspension is left only through a resume
    p_leave_on_resume_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(suspended) && !$past(rst)) |-> $past(cmd == CMD_RESUME));

    // R9: a suspend while idle changes nothing
    p_idle_suspend_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cmd == CMD_SUSPEND) |=> ($stable(flag_status) && !suspended && !busy));

endmodule

// File: tb/nor_pe_status_ctrl_test.sv
module nor_pe_status_ctrl_test;

    localparam int NS  = 4;
    localparam int EC  = 12;
    localparam int PC  = 6;
    localparam int LAT = 3;

    localparam logic [2:0] C_NONE = 3'd0, C_WREN = 3'd1, C_ERASE = 3'd2, C_PROG = 3'd3,
                           C_SUSP = 3'd4, C_RES = 3'd5, C_READ = 3'd6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_code = C_NONE;
    logic [NS-1:0] sector_lock = '0;
    logic          wel, busy, suspended;
    logic [7:0]    flag_status;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;

    always #4 clk = ~clk;

    nor_pe_status_ctrl #(
        .NUM_SECTORS(NS), .ERASE_CYCLES(EC), .PROG_CYCLES(PC), .SUSP_LATENCY(LAT)
    ) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .sector_lock(sector_lock), .wel(wel), .flag_status(flag_status),
        .busy(busy), .suspended(suspended)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // one command across exactly one rising edge; entered and left at a falling edge
    task automatic apply(input logic [2:0] c);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = C_NONE;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_valid = 1'b0;
        sector_lock = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 flags", {8'h0, flag_status}, 16'h80);
        chk("R1 wel", {15'h0, wel}, 16'h0);
        chk("R1 busy", {15'h0, busy}, 16'h0);
        chk("R1 suspended", {15'h0, suspended}, 16'h0);

        apply(C_SUSP);
        chk("R9 idle suspend", {8'h0, flag_status}, 16'h80);
        apply(C_RES);
        chk("R7 idle resume", {15'h0, suspended}, 16'h0);
        apply(C_PROG);
        chk("R2 program without wel", {15'h0, busy}, 16'h0);
        apply(C_ERASE);
        chk("R2 erase without wel", {8'h0, flag_status}, 16'h80);

        // plain program
        apply(C_WREN);
        chk("R2 wel set", {15'h0, wel}, 16'h1);
        apply(C_PROG);
        chk("R5 started", {7'h0, busy, flag_status}, 16'h100);
        idle(PC - 1);
        chk("R5 not yet done", {8'h0, flag_status}, 16'h00);
        idle(1);
        chk("R5 done", {7'h0, wel, flag_status}, 16'h080);

        // lock pattern sweep
        for (int p = 0; p < (1 << NS); p++) begin
            do_reset();
            sector_lock = NS'(p);
            apply(C_WREN);
            apply(C_ERASE);
            if (p != 0) begin
                chk("R3 reject flags", {8'h0, flag_status}, 16'hA2);
                chk("R3 reject wel", {15'h0, wel}, 16'h1);
                chk("R3 reject busy", {15'h0, busy}, 16'h0);
                sector_lock = '0;
                apply(C_ERASE);
                chk("R10 sticky during erase", {7'h0, busy, flag_status}, 16'h122);
                idle(EC - 1);
                chk("R10 before done", {8'h0, flag_status}, 16'h22);
                idle(1);
                chk("R10 after done", {7'h0, wel, flag_status}, 16'h0A2);
            end else begin
                chk("R4 accepted", {7'h0, busy, flag_status}, 16'h100);
                idle(EC - 1);
                chk("R4 not yet done", {8'h0, flag_status}, 16'h00);
                idle(1);
                chk("R4 done", {7'h0, wel, flag_status}, 16'h080);
                apply(C_ERASE);
                chk("R2 wel cleared blocks erase", {15'h0, busy}, 16'h0);
            end
        end

        // suspend sweep over both operations and every offset
        for (int o = 0; o < 2; o++) begin
            for (int d = 0; d <= ((o == 0) ? PC : EC) - 2; d++) begin
                int         dur;
                logic [7:0] sb;
                dur = (o == 0) ? PC : EC;
                sb  = (o == 0) ? 8'h04 : 8'h40;
                do_reset();
                apply(C_WREN);
                apply((o == 0) ? C_PROG : C_ERASE);
                idle(d);
                apply(C_SUSP);
                chk("R6 suspend bit", {7'h0, busy, flag_status}, {8'h0, sb});
                for (int r = 0; r < LAT - 1; r++) begin
                    apply(C_READ);
                    chk("R7 read with ready low", {7'h0, suspended, flag_status}, {8'h0, sb});
                end
                apply(C_RES);
                chk("R6 ready after latency", {8'h0, flag_status}, {8'h0, sb | 8'h80});
                chk("R7 early resume ignored", {15'h0, suspended}, 16'h0);
                apply(C_SUSP);
                chk("R9 suspend while pending", {7'h0, suspended, flag_status}, {8'h0, sb | 8'h80});
                apply(C_READ);
                chk("R7 suspended after read", {15'h0, suspended}, 16'h1);
                apply(C_SUSP);
                chk("R9 suspend while suspended", {7'h0, suspended, flag_status}, {8'h1, sb | 8'h80});
                idle(3);
                chk("R8 holds until resume", {7'h0, suspended, flag_status}, {8'h1, sb | 8'h80});
                apply(C_RES);
                chk("R8 resume clears", {6'h0, busy, suspended, flag_status}, 16'h200);
                idle(dur - d - 1);
                chk("R8 remaining count", {7'h0, busy, flag_status}, 16'h100);
                idle(1);
                chk("R8 completes", {7'h0, wel, flag_status}, 16'h080);
            end
        end

        finish_run();
    end

endmodule